// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Two-Entry Receive Queue

This block recovers frames from an asynchronous serial line and hands them to a host through a small receive queue. The line rests high. A falling edge marks a start bit, and the block checks it again half a bit later so that short glitches are ignored. It then samples 8 or 9 data bits at mid-bit, least significant bit first, and finally samples the stop bit. All timing is counted in pulses of an oversampling tick that runs at OSR times the bit rate (16 by default). The baud generator lives outside the block, so several receivers can share one tick.

Each completed frame is stored as one queue entry. An entry holds the data byte, the ninth bit and a framing-error flag, and the three leave the queue together. The host sees the oldest entry on its read outputs and removes it with a one-cycle pop strobe. In 9-bit mode an address filter can be switched on, and it drops every frame whose ninth bit is zero.

If a frame completes while the queue is full, that frame is lost and a sticky overrun flag goes high. The flag locks out further reception until the host drops the receive enable. Entries already queued stay readable while the lock is set.

Top module: `serial_rx_fifo2`

## Requirements
- R1: With `rx_en`=1 and no overrun, a high-to-low transition on `rx_serial` starts a frame. The line is sampled again OSR/2 ticks later: if it is high the frame is abandoned and nothing is stored; if it is low, each further bit is sampled OSR ticks after the previous one. Clock cycles without `os_tick` do not advance the timing.
- R2: Data bits arrive least significant first and appear on `rd_data`. With `nine_bit_mode`=0 there are 8 data bits and `rd_bit9` reads 0. With `nine_bit_mode`=1 a ninth bit follows the eighth and appears on `rd_bit9`.
- R3: A stop bit sampled as 0 stores `rd_frame_err`=1 with that entry, and a stop bit sampled as 1 stores 0. The flag stays attached to its own entry as it moves through the queue.
- R4: The queue holds DEPTH=2 entries. A third frame can be received while two entries wait, and every entry comes out in arrival order.
- R5: A frame that completes while the queue holds two entries, with no pop in the same cycle, is discarded and sets `overrun`=1.
- R6: While `overrun`=1, no frame is stored even if space is freed. Entries already queued stay readable and unchanged.
- R7: With `addr_only`=1 and `nine_bit_mode`=1, a frame whose ninth bit is 0 is discarded. It changes neither the queue nor `overrun`, even when the queue is full. With `nine_bit_mode`=0, `addr_only` has no effect.
- R8: `rd_avail` is 1 exactly when the queue is non-empty. A pop strobe on an empty queue has no effect.
- R9: A pop moves `rd_data`, `rd_bit9` and `rd_frame_err` together to the next entry, so the ninth bit and the flag must be read before popping.
- R10: While `rx_en`=0, a frame in progress is abandoned, no new frame starts and `overrun` clears. The queue contents are kept.
- R11: If a frame completes into a full queue in the same cycle as a pop, the pop frees a slot, the frame is stored and `overrun` stays 0.
- R12: After reset, `rd_avail`=0 and `overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, OSR pulses per bit time |
| rx_serial | input | 1 | Serial line, idle high (asynchronous) |
| rx_en | input | 1 | Receive enable; dropping it clears overrun |
| nine_bit_mode | input | 1 | 1 selects 9 data bits per frame |
| addr_only | input | 1 | In 9-bit mode, keep only frames with ninth bit 1 |
| rd_pop | input | 1 | Pop strobe for the head entry |
| rd_data | output | DATA_W | Data of the head entry |
| rd_bit9 | output | 1 | Ninth bit of the head entry |
| rd_frame_err | output | 1 | Framing-error flag of the head entry |
| rd_avail | output | 1 | Queue non-empty |
| overrun | output | 1 | Sticky overrun, reception locked |

## Verification
Two events can land on the same clock edge: a frame completing into a full queue, and a host pop. The bench first fills the queue with two frames. It then sends a third frame and raises the pop strobe on the exact edge where the stop bit is judged complete, a cycle it computes from the synchroniser depth and the tick counts. The run passes only if `overrun` stays low and the two remaining entries come out in order with the right data. A separate run with no pop must set `overrun`, lose the new frame, and keep the older entries intact.

// File: rtl/srx_pkg.sv
package srx_pkg;

   // Phases of the frame recovery sequence.
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_phase_e;

   // Number of data bits carried by one frame.
   function automatic int unsigned frame_bits(input int unsigned data_w, input logic nine);
      return nine ? data_w + 1 : data_w;
   endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= RESET_VAL;
            else        chain <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/srx_shifter.sv
module srx_shifter
   import srx_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line,
   input  logic              enable,
   input  logic              nine,
   output logic              frm_valid,
   output logic [DATA_W-1:0] frm_data,
   output logic              frm_bit9,
   output logic              frm_ferr
);

   localparam int unsigned MAXB  = DATA_W + 1;
   localparam int unsigned CNT_W = $clog2(OSR);
   localparam int unsigned BIT_W = $clog2(MAXB + 1);
   localparam int unsigned HALF  = OSR / 2;
   localparam logic [CNT_W-1:0] CNT_MID = CNT_W'(HALF - 1);
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(OSR - 1);

   rx_phase_e        phase;
   logic [CNT_W-1:0] cnt;
   logic [BIT_W-1:0] bitn;
   logic [BIT_W-1:0] last_idx;
   logic             nine_q;
   logic             line_q;
   logic [MAXB-1:0]  sh;

   assign last_idx = BIT_W'(frame_bits(DATA_W, nine_q) - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= RX_IDLE;
         cnt       <= '0;
         bitn      <= '0;
         nine_q    <= 1'b0;
         line_q    <= 1'b1;
         sh        <= '0;
         frm_valid <= 1'b0;
         frm_data  <= '0;
         frm_bit9  <= 1'b0;
         frm_ferr  <= 1'b0;
      end else begin
         frm_valid <= 1'b0;
         if (tick) line_q <= line;
         if (!enable) begin
            phase <= RX_IDLE;
            cnt   <= '0;
            bitn  <= '0;
         end else if (tick) begin
            unique case (phase)
               RX_IDLE: begin
                  if (line_q && !line) begin
                     phase  <= RX_START;
                     cnt    <= '0;
                     nine_q <= nine;
                  end
               end
               RX_START: begin
                  if (cnt == CNT_MID) begin
                     cnt   <= '0;
                     bitn  <= '0;
                     phase <= line ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt == CNT_END) begin
                     cnt <= '0;
                     sh  <= {line, sh[MAXB-1:1]};
                     if (bitn == last_idx) phase <= RX_STOP;
                     else                  bitn  <= bitn + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt == CNT_END) begin
                     cnt       <= '0;
                     phase     <= RX_IDLE;
                     frm_valid <= 1'b1;
                     frm_ferr  <= ~line;
                     if (nine_q) begin
                        frm_data <= sh[DATA_W-1:0];
                        frm_bit9 <= sh[DATA_W];
                     end else begin
                        frm_data <= sh[MAXB-1:1];
                        frm_bit9 <= 1'b0;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: phase <= RX_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/srx_queue.sv
module srx_queue #(
   parameter int unsigned DEPTH = 2,
   parameter int unsigned W     = 10
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic                       pop,
   input  logic [W-1:0]               wdata,
   output logic [W-1:0]               rdata,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       empty,
   output logic                       full
);

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp, rp, wp_nx, rp_nx;
   logic             pop_eff;

   assign pop_eff = pop & ~empty;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) begin
            mem[wp] <= wdata;
            wp      <= wp_nx;
         end
         if (pop_eff) rp <= rp_nx;
         if (push && !pop_eff)      count <= count + 1'b1;
         else if (pop_eff && !push) count <= count - 1'b1;
      end
   end

   assign rdata = mem[rp];
   assign empty = (count == '0);
   assign full  = (count == CNT_W'(DEPTH));

endmodule

// File: rtl/serial_rx_fifo2.sv
module serial_rx_fifo2
   import srx_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DEPTH       = 2,
   parameter int unsigned OSR         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              rx_serial,
   input  logic              rx_en,
   input  logic              nine_bit_mode,
   input  logic              addr_only,
   input  logic              rd_pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_bit9,
   output logic              rd_frame_err,
   output logic              rd_avail,
   output logic              overrun
);

   localparam int unsigned ENT_W = DATA_W + 2;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("DATA_W must be at least 4");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("OSR must be even and at least 4");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic              line_s;
   logic              frm_valid;
   logic [DATA_W-1:0] frm_data;
   logic              frm_bit9;
   logic              frm_ferr;
   logic              filter_drop;
   logic              accept;
   logic              pop_eff;
   logic              q_push;
   logic              q_empty;
   logic              q_full;
   logic [CNT_W-1:0]  q_count;
   logic [ENT_W-1:0]  q_rdata;
   logic              ovr_set;

   srx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_serial),
      .q     (line_s)
   );

   srx_shifter #(.DATA_W(DATA_W), .OSR(OSR)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (os_tick),
      .line      (line_s),
      .enable    (rx_en & ~overrun),
      .nine      (nine_bit_mode),
      .frm_valid (frm_valid),
      .frm_data  (frm_data),
      .frm_bit9  (frm_bit9),
      .frm_ferr  (frm_ferr)
   );

   assign filter_drop = addr_only & nine_bit_mode & ~frm_bit9;
   assign accept      = frm_valid & ~filter_drop;
   assign pop_eff     = rd_pop & ~q_empty;
   assign q_push      = accept & (~q_full | pop_eff);
   assign ovr_set     = accept & q_full & ~pop_eff;

   srx_queue #(.DEPTH(DEPTH), .W(ENT_W)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push),
      .pop   (rd_pop),
      .wdata ({frm_ferr, frm_bit9, frm_data}),
      .rdata (q_rdata),
      .count (q_count),
      .empty (q_empty),
      .full  (q_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       overrun <= 1'b0;
      else if (!rx_en)  overrun <= 1'b0;
      else if (ovr_set) overrun <= 1'b1;
   end

   assign {rd_frame_err, rd_bit9, rd_data} = q_rdata;
   assign rd_avail = ~q_empty;

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
   parameter int unsigned DEPTH = 2,
   parameter int unsigned CNT_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_en,
   input logic             rd_pop,
   input logic             rd_avail,
   input logic             overrun,
   input logic             addr_only,
   input logic             nine_bit_mode,
   input logic             q_push,
   input logic             q_bit9,
   input logic [CNT_W-1:0] q_count
);

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CNT_W'(DEPTH));

   p_overrun_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(q_count) == CNT_W'(DEPTH));

   p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && rx_en) |=> overrun);

   p_locked_no_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> !q_push);

   p_addr_filter_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (q_push && addr_only && nine_bit_mode) |-> q_bit9);

   p_avail_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_avail == (q_count != '0));

   p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_avail && rd_pop && !q_push) |=> !rd_avail);

   p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !overrun);

endmodule

bind serial_rx_fifo2 srx_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_srx_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rx_en         (rx_en),
   .rd_pop        (rd_pop),
   .rd_avail      (rd_avail),
   .overrun       (overrun),
   .addr_only     (addr_only),
   .nine_bit_mode (nine_bit_mode),
   .q_push        (q_push),
   .q_bit9        (frm_bit9),
   .q_count       (q_count)
);

// File: tb/serial_rx_fifo2_bench.sv
`timescale 1ns/1ps
module serial_rx_fifo2_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b1;
   logic       rx_serial = 1'b1;
   logic       rx_en = 1'b1;
   logic       nine_bit_mode = 1'b0;
   logic       addr_only = 1'b0;
   logic       rd_pop = 1'b0;
   logic [7:0] rd_data;
   logic       rd_bit9, rd_frame_err, rd_avail, overrun;

   int n_chk = 0;
   int n_fail = 0;
   int tick_div = 1;
   int tick_cnt = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   serial_rx_fifo2 u_serial_rx_fifo2 (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_serial(rx_serial),
      .rx_en(rx_en), .nine_bit_mode(nine_bit_mode), .addr_only(addr_only),
      .rd_pop(rd_pop), .rd_data(rd_data), .rd_bit9(rd_bit9),
      .rd_frame_err(rd_frame_err), .rd_avail(rd_avail), .overrun(overrun)
   );

   always @(negedge clk) begin
      if (tick_div <= 1) begin
         os_tick = 1'b1;
      end else begin
         os_tick  = (tick_cnt == 0);
         tick_cnt = (tick_cnt + 1) % tick_div;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [8:0] v, input int nb, input logic stopv);
      int bt;
      bt = 16 * tick_div;
      @(negedge clk); rx_serial = 1'b0; repeat (bt - 1) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         @(negedge clk); rx_serial = v[i]; repeat (bt - 1) @(negedge clk);
      end
      @(negedge clk); rx_serial = stopv; repeat (bt - 1) @(negedge clk);
      @(negedge clk); rx_serial = 1'b1; repeat (2 * bt - 1) @(negedge clk);
   endtask

   task automatic head(input string tag, input logic [7:0] d, input logic b9, input logic fe);
      check({tag, " avail"}, 32'(rd_avail), 32'd1);
      check({tag, " data"},  32'(rd_data),  32'(d));
      check({tag, " bit9"},  32'(rd_bit9),  32'(b9));
      check({tag, " ferr"},  32'(rd_frame_err), 32'(fe));
   endtask

   task automatic pop1();
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      check("R12 avail", 32'(rd_avail), 32'd0);
      check("R12 overrun", 32'(overrun), 32'd0);

      // R8 pop on empty has no effect
      pop1();
      check("R8 empty pop", 32'(rd_avail), 32'd0);

      // R2 exhaustive 8-bit sweep, R8 avail falls after last pop
      for (int v = 0; v < 256; v++) begin
         send(9'(v), 8, 1'b1);
         head("R2 8bit", 8'(v), 1'b0, 1'b0);
         pop1();
         check("R8 drained", 32'(rd_avail), 32'd0);
      end

      // R2 9-bit mode sweep
      nine_bit_mode = 1'b1;
      for (int i = 0; i < 64; i++) begin
         logic [8:0] w;
         w = {i[0], 8'((i * 37 + 5) & 255)};
         send(w, 9, 1'b1);
         head("R2 9bit", w[7:0], w[8], 1'b0);
         pop1();
      end

      // R3 / R9 framing flag travels with its entry
      send(9'h1C3, 9, 1'b0);
      send(9'h024, 9, 1'b1);
      head("R3 ferr first", 8'hC3, 1'b1, 1'b1);
      pop1();
      head("R9 next entry", 8'h24, 1'b0, 1'b0);
      pop1();
      nine_bit_mode = 1'b0;
      send(9'h03C, 8, 1'b0);
      send(9'h081, 8, 1'b1);
      head("R3 ferr 8bit", 8'h3C, 1'b0, 1'b1);
      pop1();
      head("R9 flag cleared", 8'h81, 1'b0, 1'b0);
      pop1();

      // R1 glitch on the start bit is rejected
      @(negedge clk); rx_serial = 1'b0;
      repeat (4) @(negedge clk);
      rx_serial = 1'b1;
      repeat (64) @(negedge clk);
      check("R1 glitch ignored", 32'(rd_avail), 32'd0);
      send(9'h05A, 8, 1'b1);
      head("R1 after glitch", 8'h5A, 1'b0, 1'b0);
      pop1();

      // R1 timing counted in ticks only (tick every third cycle)
      tick_div = 3;
      send(9'h0C3, 8, 1'b1);
      send(9'h03C, 8, 1'b1);
      head("R1 slow tick a", 8'hC3, 1'b0, 1'b0);
      pop1();
      head("R1 slow tick b", 8'h3C, 1'b0, 1'b0);
      pop1();
      tick_div = 1;
      repeat (4) @(negedge clk);

      // R4 / R5 / R6 / R10 overrun and lock
      send(9'h011, 8, 1'b1);
      send(9'h022, 8, 1'b1);
      check("R4 two held", 32'(rd_avail), 32'd1);
      check("R4 no overrun", 32'(overrun), 32'd0);
      send(9'h033, 8, 1'b1);
      check("R5 overrun set", 32'(overrun), 32'd1);
      head("R5 first kept", 8'h11, 1'b0, 1'b0);
      pop1();
      send(9'h044, 8, 1'b1);
      check("R6 still locked", 32'(overrun), 32'd1);
      head("R6 second kept", 8'h22, 1'b0, 1'b0);
      rx_en = 1'b0;
      @(negedge clk);
      check("R10 overrun cleared", 32'(overrun), 32'd0);
      rx_en = 1'b1;
      head("R6 retained over re-arm", 8'h22, 1'b0, 1'b0);
      pop1();
      check("R6 locked frame lost", 32'(rd_avail), 32'd0);
      send(9'h055, 8, 1'b1);
      head("R10 re-armed", 8'h55, 1'b0, 1'b0);
      pop1();

      // R10 disable during a frame
      fork
         send(9'h099, 8, 1'b1);
         begin
            repeat (40) @(negedge clk);
            rx_en = 1'b0;
         end
      join
      check("R10 frame abandoned", 32'(rd_avail), 32'd0);
      rx_en = 1'b1;
      @(negedge clk);
      send(9'h042, 8, 1'b1);
      head("R10 after abandon", 8'h42, 1'b0, 1'b0);
      pop1();

      // R11 pop and completion on the same edge
      send(9'h0A1, 8, 1'b1);
      send(9'h0B2, 8, 1'b1);
      head("R11 head before", 8'hA1, 1'b0, 1'b0);
      fork
         send(9'h0C4, 8, 1'b1);
         begin
            @(negedge clk);
            repeat (155) @(negedge clk);
            rd_pop = 1'b1;
            @(negedge clk);
            rd_pop = 1'b0;
         end
      join
      check("R11 no overrun", 32'(overrun), 32'd0);
      head("R11 second", 8'hB2, 1'b0, 1'b0);
      pop1();
      head("R11 third stored", 8'hC4, 1'b0, 1'b0);
      pop1();
      check("R11 drained", 32'(rd_avail), 32'd0);

      // R7 address filter
      nine_bit_mode = 1'b1;
      addr_only = 1'b1;
      send(9'h0A5, 9, 1'b1);
      check("R7 data frame dropped", 32'(rd_avail), 32'd0);
      send(9'h1A5, 9, 1'b1);
      send(9'h1B6, 9, 1'b1);
      send(9'h0C7, 9, 1'b1);
      check("R7 drop while full", 32'(overrun), 32'd0);
      head("R7 addr kept a", 8'hA5, 1'b1, 1'b0);
      pop1();
      head("R7 addr kept b", 8'hB6, 1'b1, 1'b0);
      pop1();
      check("R7 nothing else", 32'(rd_avail), 32'd0);
      nine_bit_mode = 1'b0;
      send(9'h077, 8, 1'b1);
      head("R7 ignored in 8bit", 8'h77, 1'b0, 1'b0);
      pop1();
      addr_only = 1'b0;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule